// File: doc/BRIEF.md
# Dual-Reference Triangle-Carrier Gate Generator

This block produces the nine gate signals of a three-leg converter in which every leg stacks three switches and feeds two independent three-phase loads. One symmetric up/down carrier is shared by all legs. Each leg takes two unsigned reference samples: one for the load fed from the top of the leg and one for the load fed from the bottom. The top switch conducts while the carrier is below the top reference. The bottom switch conducts while the carrier is at or above the bottom reference. The middle switch is the exclusive-or of the other two. As long as the top reference is not below the bottom one, exactly two switches of a leg conduct.

References are captured only when the carrier turns at its peak, so a leg never sees a reference change in the middle of a carrier slope. A capture whose bottom value exceeds its top value is repaired by using the top value for both, and a sticky flag records the fault until reset. A programmable dead time holds back every gate that is about to turn on, while gates that turn off do so at once, so two switches of a leg never overlap.

The carrier runs as a two-state machine. It stays in CAR_RISE, counting up, until the count reaches the period; that is the peak, where it moves to CAR_FALL. It stays in CAR_FALL, counting down, until the count reaches 1, then returns to CAR_RISE at zero. Each leg runs its own two-state machine. In LEG_RUN the gates follow the comparator pattern; when a new pattern needs a gate to turn on and the dead time is nonzero, the leg moves to LEG_HOLD. In LEG_HOLD the leg keeps only the gates that stay on and counts the dead time down. When that count reaches 1, or the dead time is set to zero, it applies the full pattern and returns to LEG_RUN.

Top module: `dual_ref_pwm_gen`

## Requirements
- R1: The carrier starts at 0 after reset and steps by one each clock, rising to `period_i` and falling back to 0, for a full cycle of 2*`period_i` clocks. `peak_o` is high exactly in the clock where the rising carrier equals `period_i`.
- R2: The reference inputs are captured only on the clock edge that ends a peak clock. A change at any other time has no effect on the gates until the next peak has passed.
- R3: With zero dead time, the top gate of leg j (bit j, leg A = bit 0) is high in the clock after a clock in which carrier < captured top reference of leg j. Leg j's references are `ref_up_i[j*8 +: 8]` and `ref_dn_i[j*8 +: 8]` at the default width of 8.
- R4: With zero dead time, the bottom gate of a leg is high in the clock after a clock in which carrier >= captured bottom reference. The middle gate equals top XOR bottom, so exactly two gates of each leg are high.
- R5: A capture whose bottom reference exceeds its top reference stores the top value as the bottom reference and sets `order_err_o`. The flag stays high until reset.
- R6: With dead time d > 0, a gate that turns off does so in the same clock as it would with zero dead time. A gate that turns on does so d clocks later. No leg ever has all three gates high.
- R7: During reset all gates are low, the carrier is 0, `order_err_o` is low and both captured references of every leg are 0.
- R8: A top reference above `period_i` keeps the top gate high for the whole cycle. A top reference of 0 keeps it low. A bottom reference of 0 keeps the bottom gate high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CW | Carrier peak count |
| dead_i | input | DTW | Turn-on delay in clocks |
| ref_up_i | input | LEGS*CW | Top-load references, leg j at [j*CW +: CW] |
| ref_dn_i | input | LEGS*CW | Bottom-load references, leg j at [j*CW +: CW] |
| carrier_o | output | CW | Current carrier count |
| peak_o | output | 1 | High in the peak clock |
| gate_up_o | output | LEGS | Top switch gates |
| gate_mid_o | output | LEGS | Middle switch gates |
| gate_dn_o | output | LEGS | Bottom switch gates |
| order_err_o | output | 1 | Sticky reference-order fault |

## Verification
The bench builds the block with its default parameters: 8-bit counts, a 4-bit dead-time counter and three legs. It drives a period of 10, so a whole carrier cycle lasts only 20 clocks, and reference values of 0, the period and one above the period are easy to reach. The dead time is swept between 0 and 3. A delay of 3 fits inside every slope, so both the delayed turn-on of the middle gate and the delayed turn-on of the top gate can be timed exactly.

// File: rtl/dpg_pkg.sv
`timescale 1ns/1ps
package dpg_pkg;
    typedef enum logic {CAR_RISE, CAR_FALL} car_state_t;
    typedef enum logic {LEG_RUN, LEG_HOLD} leg_state_t;
    localparam int GATE_UP  = 2;
    localparam int GATE_MID = 1;
    localparam int GATE_DN  = 0;
    localparam int GATES_PER_LEG = 3;
endpackage

// File: rtl/dpg_carrier.sv
`timescale 1ns/1ps
module dpg_carrier
    import dpg_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] count_o,
    output logic          peak_o
);
    car_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CAR_RISE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CAR_RISE: begin
                if (cnt_q >= period_i) begin
                    st_d  = CAR_FALL;
                    cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CAR_FALL: begin
                if (cnt_q <= 1) begin
                    st_d  = CAR_RISE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    assign count_o = cnt_q;
    assign peak_o  = (st_q == CAR_RISE) && (cnt_q >= period_i);
endmodule

// File: rtl/dpg_leg.sv
`timescale 1ns/1ps
module dpg_leg
    import dpg_pkg::*;
#(
    parameter int CW  = 8,
    parameter int DTW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CW-1:0]            carrier_i,
    input  logic                     load_i,
    input  logic [CW-1:0]            ref_up_i,
    input  logic [CW-1:0]            ref_dn_i,
    input  logic [DTW-1:0]           dead_i,
    output logic [GATES_PER_LEG-1:0] gates_o,
    output logic                     viol_o
);
    logic [CW-1:0] up_q, dn_q;
    logic          misorder;

    assign misorder = ref_dn_i > ref_up_i;
    assign viol_o   = load_i && misorder;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= '0;
            dn_q <= '0;
        end else if (load_i) begin
            up_q <= ref_up_i;
            dn_q <= misorder ? ref_up_i : ref_dn_i;
        end
    end

    logic [GATES_PER_LEG-1:0] tgt;
    always_comb begin
        tgt[GATE_UP]  = carrier_i < up_q;
        tgt[GATE_DN]  = carrier_i >= dn_q;
        tgt[GATE_MID] = tgt[GATE_UP] ^ tgt[GATE_DN];
    end

    leg_state_t               st_q, st_d;
    logic [GATES_PER_LEG-1:0] on_q, on_d;
    logic [DTW-1:0]           dt_q, dt_d;
    logic                     rising;

    assign rising = |(tgt & ~on_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= LEG_RUN;
            on_q <= '0;
            dt_q <= '0;
        end else begin
            st_q <= st_d;
            on_q <= on_d;
            dt_q <= dt_d;
        end
    end

    always_comb begin
        st_d = st_q;
        on_d = on_q;
        dt_d = dt_q;
        unique case (st_q)
            LEG_RUN: begin
                if (tgt != on_q) begin
                    if (!rising || dead_i == '0) begin
                        on_d = tgt;
                    end else begin
                        on_d = on_q & tgt;
                        dt_d = dead_i;
                        st_d = LEG_HOLD;
                    end
                end
            end
            LEG_HOLD: begin
                if (dead_i == '0 || dt_q <= 1) begin
                    on_d = tgt;
                    dt_d = '0;
                    st_d = LEG_RUN;
                end else begin
                    on_d = on_q & tgt;
                    dt_d = dt_q - 1'b1;
                end
            end
        endcase
    end

    assign gates_o = on_q;
endmodule

// File: rtl/dual_ref_pwm_gen.sv
`timescale 1ns/1ps
module dual_ref_pwm_gen
    import dpg_pkg::*;
#(
    parameter int CW   = 8,
    parameter int DTW  = 4,
    parameter int LEGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      period_i,
    input  logic [DTW-1:0]     dead_i,
    input  logic [LEGS*CW-1:0] ref_up_i,
    input  logic [LEGS*CW-1:0] ref_dn_i,
    output logic [CW-1:0]      carrier_o,
    output logic               peak_o,
    output logic [LEGS-1:0]    gate_up_o,
    output logic [LEGS-1:0]    gate_mid_o,
    output logic [LEGS-1:0]    gate_dn_o,
    output logic               order_err_o
);
    logic [CW-1:0]   carrier;
    logic            peak;
    logic [LEGS-1:0] viol;
    logic            err_q;

    dpg_carrier #(.CW(CW)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .count_o  (carrier),
        .peak_o   (peak)
    );

    for (genvar j = 0; j < LEGS; j++) begin : g_leg
        logic [GATES_PER_LEG-1:0] gates;
        dpg_leg #(.CW(CW), .DTW(DTW)) u_leg (
            .clk       (clk),
            .rst_n     (rst_n),
            .carrier_i (carrier),
            .load_i    (peak),
            .ref_up_i  (ref_up_i[j*CW +: CW]),
            .ref_dn_i  (ref_dn_i[j*CW +: CW]),
            .dead_i    (dead_i),
            .gates_o   (gates),
            .viol_o    (viol[j])
        );
        assign gate_up_o[j]  = gates[GATE_UP];
        assign gate_mid_o[j] = gates[GATE_MID];
        assign gate_dn_o[j]  = gates[GATE_DN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else if (|viol) err_q <= 1'b1;
    end

    assign carrier_o   = carrier;
    assign peak_o      = peak;
    assign order_err_o = err_q;
endmodule

// File: rtl/dual_ref_pwm_gen_chk.sv
`timescale 1ns/1ps
module dual_ref_pwm_gen_chk #(
    parameter int CW   = 8,
    parameter int DTW  = 4,
    parameter int LEGS = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DTW-1:0]  dead_i,
    input logic [CW-1:0]   carrier_o,
    input logic            peak_o,
    input logic [LEGS-1:0] gate_up_o,
    input logic [LEGS-1:0] gate_mid_o,
    input logic [LEGS-1:0] gate_dn_o,
    input logic            order_err_o
);
    // R1
    carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
            ({1'b0, carrier_o} == {1'b0, $past(carrier_o)} + 1'b1) ||
            ({1'b0, carrier_o} + 1'b1 == {1'b0, $past(carrier_o)}) ||
            (carrier_o == '0 && $past(carrier_o) == '0));

    // R1
    peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |=> (carrier_o == '0) ||
                   ({1'b0, carrier_o} + 1'b1 == {1'b0, $past(carrier_o)}));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err_o |=> order_err_o);

    for (genvar j = 0; j < LEGS; j++) begin : g_legchk
        // R6
        no_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_up_o[j] && gate_mid_o[j] && gate_dn_o[j]));

        // R4
        two_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dead_i) == '0) |->
                ($countones({gate_up_o[j], gate_mid_o[j], gate_dn_o[j]}) == 2 &&
                 gate_mid_o[j] == (gate_up_o[j] ^ gate_dn_o[j])));
    end
endmodule

bind dual_ref_pwm_gen dual_ref_pwm_gen_chk #(.CW(CW), .DTW(DTW), .LEGS(LEGS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dead_i      (dead_i),
    .carrier_o   (carrier_o),
    .peak_o      (peak_o),
    .gate_up_o   (gate_up_o),
    .gate_mid_o  (gate_mid_o),
    .gate_dn_o   (gate_dn_o),
    .order_err_o (order_err_o)
);

// File: tb/dual_ref_pwm_gen_bench.sv
`timescale 1ns/1ps
module dual_ref_pwm_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 8;
    localparam int DTW  = 4;
    localparam int LEGS = 3;
    localparam int P    = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [CW-1:0]      period = CW'(P);
    logic [DTW-1:0]     dead = '0;
    logic [LEGS*CW-1:0] ref_up = '0;
    logic [LEGS*CW-1:0] ref_dn = '0;
    logic [CW-1:0]      carrier;
    logic               peak;
    logic [LEGS-1:0]    g_up, g_mid, g_dn;
    logic               oerr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_ref_pwm_gen #(.CW(CW), .DTW(DTW), .LEGS(LEGS)) u_dual_ref_pwm_gen (
        .clk (clk), .rst_n (rst_n), .period_i (period), .dead_i (dead),
        .ref_up_i (ref_up), .ref_dn_i (ref_dn), .carrier_o (carrier),
        .peak_o (peak), .gate_up_o (g_up), .gate_mid_o (g_mid),
        .gate_dn_o (g_dn), .order_err_o (oerr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    int bhi [LEGS];
    int blo [LEGS];
    int m_hi [LEGS];
    int m_lo [LEGS];
    int m_phi [LEGS];
    int m_plo [LEGS];
    int m_prevcar;
    bit m_pend, m_valid, m_err;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic set_ref(int j, int hi, int lo);
        bhi[j] = hi;
        blo[j] = lo;
        ref_up[j*CW +: CW] = CW'(hi);
        ref_dn[j*CW +: CW] = CW'(lo);
    endtask

    // Advance n clocks, keeping the reference model in step; optionally compare gates.
    task automatic track(int n, bit do_chk, string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (m_pend) begin
                for (int j = 0; j < LEGS; j++) begin
                    m_hi[j] = bhi[j];
                    m_lo[j] = (blo[j] > bhi[j]) ? bhi[j] : blo[j];
                    if (blo[j] > bhi[j]) m_err = 1;
                end
            end
            if (m_valid && do_chk) begin
                for (int j = 0; j < LEGS; j++) begin
                    bit eu, ed;
                    eu = m_prevcar < m_phi[j];
                    ed = m_prevcar >= m_plo[j];
                    chk(g_up[j] == eu, req, $sformatf("leg%0d top gate", j), int'(g_up[j]), int'(eu));
                    chk(g_dn[j] == ed, req, $sformatf("leg%0d bottom gate", j), int'(g_dn[j]), int'(ed));
                    chk(g_mid[j] == (eu ^ ed), req, $sformatf("leg%0d middle gate", j),
                        int'(g_mid[j]), int'(eu ^ ed));
                end
                chk(oerr == m_err, req, "order flag", int'(oerr), int'(m_err));
            end
            m_prevcar = int'(carrier);
            for (int j = 0; j < LEGS; j++) begin
                m_phi[j] = m_hi[j];
                m_plo[j] = m_lo[j];
            end
            m_pend  = (int'(carrier) == P);
            m_valid = 1;
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        dead  = '0;
        for (int j = 0; j < LEGS; j++) set_ref(j, 0, 0);
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(g_up == '0 && g_mid == '0 && g_dn == '0, "R7", "gates in reset",
            int'({g_up, g_mid, g_dn}), 0);
        chk(carrier == '0, "R7", "carrier in reset", int'(carrier), 0);
        chk(oerr == 1'b0, "R7", "order flag in reset", int'(oerr), 0);
        for (int j = 0; j < LEGS; j++) begin
            m_hi[j] = 0; m_lo[j] = 0; m_phi[j] = 0; m_plo[j] = 0;
        end
        m_pend = 0; m_valid = 0; m_err = 0;
        rst_n = 1;
        // R7: zero references act from the first cycle (top off, bottom and middle on)
        track(2 * P, 1, "R7");
    endtask

    task automatic t_carrier();
        int guard = 0;
        while (int'(carrier) != 0 && guard < 4 * P) begin
            track(1, 1, "R1");
            guard++;
        end
        for (int k = 0; k <= 2 * P; k++) begin
            int ec;
            ec = (k <= P) ? k : 2 * P - k;
            chk(int'(carrier) == ec, "R1", "carrier value", int'(carrier), ec);
            chk(peak == (ec == P), "R1", "peak flag", int'(peak), int'(ec == P));
            track(1, 1, "R1");
        end
    endtask

    task automatic t_basic();
        set_ref(0, 6, 2);
        set_ref(1, 8, 5);
        set_ref(2, 3, 3);
        track(3 * 2 * P, 1, "R3 R4");
    endtask

    task automatic t_latch();
        bit passed_zero = 0;
        int guard = 0;
        while (int'(carrier) != P) track(1, 1, "R2");
        track(4, 1, "R2");
        // falling slope: new top reference for leg A must wait for the next peak
        set_ref(0, 9, 2);
        while (guard < 4 * P) begin
            track(1, 1, "R2");
            guard++;
            if (int'(carrier) == 0) passed_zero = 1;
            if (passed_zero && int'(carrier) == 8) break;
        end
        track(1, 0, "R2");
        // previous clock had carrier 8 on the rise; old top reference 6 gives 0, new 9 would give 1
        chk(g_up[0] == 1'b0, "R2", "top gate before next peak", int'(g_up[0]), 0);
        track(2 * P, 1, "R2");
    endtask

    task automatic t_bound();
        set_ref(0, P + 1, 0);
        set_ref(1, 0, 0);
        set_ref(2, P, P);
        track(2 * P, 1, "R8");
        for (int k = 0; k < 2 * P; k++) begin
            track(1, 1, "R8");
            chk(g_up[0] == 1'b1, "R8", "top gate above period", int'(g_up[0]), 1);
            chk(g_up[1] == 1'b0, "R8", "top gate at zero", int'(g_up[1]), 0);
            chk(g_dn[0] == 1'b1, "R8", "bottom gate at zero", int'(g_dn[0]), 1);
        end
    endtask

    task automatic t_order();
        set_ref(0, 6, 2);
        set_ref(1, 3, 7);
        set_ref(2, 5, 1);
        track(3 * P, 1, "R5");
        chk(oerr == 1'b1, "R5", "order flag raised", int'(oerr), 1);
        set_ref(1, 7, 3);
        track(3 * P, 1, "R5");
        chk(oerr == 1'b1, "R5", "order flag sticky", int'(oerr), 1);
    endtask

    task automatic t_dead();
        int phase = 0;
        int gap = 0;
        bit pu, pm;
        set_ref(0, 6, 2);
        set_ref(1, 7, 3);
        set_ref(2, 5, 1);
        track(2 * P, 1, "R6");
        dead = DTW'(3);
        track(2 * P, 0, "R6");
        pu = g_up[0];
        pm = g_mid[0];
        for (int k = 0; k < 6 * P && phase < 4; k++) begin
            track(1, 0, "R6");
            for (int j = 0; j < LEGS; j++) begin
                int c;
                c = int'(g_up[j]) + int'(g_mid[j]) + int'(g_dn[j]);
                chk(c >= 1 && c <= 2, "R6", $sformatf("leg%0d gates on", j), c, 2);
            end
            case (phase)
                0: if (pu && !g_up[0]) begin phase = 1; gap = 1; end
                1: if (g_mid[0]) begin
                       chk(gap == 3, "R6", "middle turn-on delay", gap, 3);
                       phase = 2;
                   end else gap++;
                2: if (pm && !g_mid[0]) begin phase = 3; gap = 1; end
                3: if (g_up[0]) begin
                       chk(gap == 3, "R6", "top turn-on delay", gap, 3);
                       phase = 4;
                   end else gap++;
                default: ;
            endcase
            pu = g_up[0];
            pm = g_mid[0];
        end
        chk(phase == 4, "R6", "both delayed edges seen", phase, 4);
        dead = '0;
        track(2, 0, "R6");
        track(2 * P, 1, "R6");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        summary();
    end

    initial begin
        t_reset();
        t_carrier();
        t_basic();
        t_latch();
        t_bound();
        t_order();
        t_dead();
        summary();
    end
endmodule